// File: doc/BRIEF.md
# DMA Channel Attribute Register Bank

This block is the software-visible control and status bank of a 32-channel DMA controller. A processor reaches it over a plain single-cycle register bus: a write takes effect on the clock edge where select and write are both high, and read data is returned combinationally for the address presented. The bank holds a global run bit and five per-channel bit vectors: channel enable, burst-only, alternate-structure select, high priority and request mask. It also holds the control table base, a software request strobe, completion status, a bus error flag and four words of channel-to-peripheral mapping.

Each per-channel vector is reached through two word addresses. Writing ones at the first address raises those bits, and writing ones at the second address drops them, so no read-modify-write is needed and other channels are never disturbed. The transfer engine reports completion per channel. A completion drops that channel's enable bit and latches its status bit. Peripheral requests reach the engine only for channels that are enabled and unmasked while the global run bit is set.

Word addresses, 5 bits wide: 0x00 global run bit (bit 0), 0x01 table base, 0x02 alternate base (read only), 0x03 software request, 0x04/0x05 enable raise/drop, 0x06/0x07 burst-only raise/drop, 0x08/0x09 alternate select raise/drop, 0x0A/0x0B priority raise/drop, 0x0C/0x0D mask raise/drop, 0x0E error flag (bit 0), 0x0F completion status, 0x10 to 0x13 map words.

Top module: `dma_attr_regs`

## Requirements
- R1: A write to a vector's raise address (0x04, 0x06, 0x08, 0x0A, 0x0C) sets every bit that is 1 in the write data. Bits written 0 keep their value, and the new value appears on the vector's output port after that edge.
- R2: A write to a vector's drop address (the raise address plus 1) clears every bit that is 1 in the write data. Bits written 0 keep their value.
- R3: A read of a raise address returns the current vector. A read of a drop address, or of the software request address, returns zero.
- R4: When bit n of `xfer_done` is high at an edge, enable bit n is 0 and completion status bit n is 1 after that edge.
- R5: The global run bit is bit 0 of address 0x00 and reads back there. While it is 0, `req_to_engine` and `sw_req` stay all zero.
- R6: A write to 0x03 while the run bit is 1 drives `sw_req` to the write data for exactly the one cycle after the write edge. The cycle after that, `sw_req` is zero.
- R7: A high `bus_err` sets the error flag, which reads as 1 at bit 0 of 0x0E. Writing 1 to bit 0 clears it, writing 0 leaves it set, and a new error in the same cycle as the clear keeps it set.
- R8: Completion status at 0x0F can hold several bits at once. Writing 1 to a bit clears only that bit, and a completion in the same cycle wins over the clear.
- R9: The map nibble of channel n is held in word 0x10 + n/8 at bits (n%8)*4+3 down to (n%8)*4. It reads back at that address and drives `chan_map` bits 4n+3 down to 4n.
- R10: The table base ignores write bits 9 to 0 and reads back with them zero. The alternate base at 0x02 reads as the base plus 0x200.
- R11: `req_to_engine` bit n is high exactly when `periph_req` bit n is high, enable bit n is 1, mask bit n is 0 and the run bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register bus select |
| reg_wr | input | 1 | Write strobe, qualified by select |
| reg_addr | input | 5 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| xfer_done | input | 32 | Per-channel completion pulses from the engine |
| bus_err | input | 1 | Bus error pulse from the engine |
| periph_req | input | 32 | Per-channel peripheral requests |
| master_en | output | 1 | Global run bit |
| chan_en | output | 32 | Channel enable vector |
| chan_burst | output | 32 | Burst-only vector |
| chan_alt | output | 32 | Alternate-structure select vector |
| chan_prio | output | 32 | High-priority vector |
| chan_mask | output | 32 | Request mask vector |
| sw_req | output | 32 | One-cycle software request pulses |
| req_to_engine | output | 32 | Gated peripheral requests |
| done_status | output | 32 | Completion status vector |
| err_pending | output | 1 | Error flag |
| chan_map | output | 128 | Four map bits per channel |
| table_base | output | 32 | Control table base with bits 9:0 zero |

## Verification
The set and clear paths of every vector are tried with a mixed pattern of alternating nibbles, then a single added bit, then a partial clear, and then all-zero writes. These tell apart OR/AND-NOT updates from plain overwrites and show whether the raise and drop addresses are swapped. The completion test uses two enabled channels with only one finishing, which separates a per-bit clear from a whole-vector clear. Request gating uses overlapping enable and mask patterns under all-ones peripheral requests, followed by the run bit turned off. The map test writes distinct nibbles to one word and checks the first and last channel of that group, which catches a wrong word index or a wrong nibble offset.

// File: rtl/dma_attr_pkg.sv
package dma_attr_pkg;
  localparam int ADDR_W = 5;
  typedef logic [ADDR_W-1:0] regaddr_t;

  localparam regaddr_t A_RUN     = 5'h00;
  localparam regaddr_t A_BASE    = 5'h01;
  localparam regaddr_t A_ALTBASE = 5'h02;
  localparam regaddr_t A_SWREQ   = 5'h03;
  localparam regaddr_t A_ATTR0   = 5'h04; // raise/drop pairs start here
  localparam regaddr_t A_ERR     = 5'h0E;
  localparam regaddr_t A_STAT    = 5'h0F;
  localparam regaddr_t A_MAP0    = 5'h10;

  localparam int N_ATTR   = 5;
  localparam int AT_EN    = 0;
  localparam int AT_BURST = 1;
  localparam int AT_ALT   = 2;
  localparam int AT_PRIO  = 3;
  localparam int AT_MASK  = 4;

  localparam int MAP_BITS = 4;
  localparam int BASE_LSB = 10;
  localparam int ALT_OFS  = 32'h200;
endpackage

// File: rtl/dma_bitvec.sv
module dma_bitvec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] hw_clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         q_ce;

  always_comb begin
    q_nxt = q & ~hw_clr;
    if (set_we) q_nxt = q_nxt | wmask;
    if (clr_we) q_nxt = q_nxt & ~wmask;
  end

  assign q_ce = set_we | clr_we | (|hw_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_ce) q <= q_nxt;
  end

  assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wmask)) == $past(wmask)));

  assert_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & $past(wmask)) == '0));

  assert_hwclr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hw_clr) && !set_we) |=> ((q & $past(hw_clr)) == '0));
endmodule

// File: rtl/dma_chmap.sv
module dma_chmap #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [DATA_W-1:0]       wdata,
  output logic [WORDS*DATA_W-1:0] map_flat
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              w_ce;
    logic [DATA_W-1:0] w_q;

    assign w_ce = we && (idx == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    w_q <= '0;
      else if (w_ce) w_q <= wdata;
    end

    assign map_flat[w*DATA_W +: DATA_W] = w_q;
  end
endmodule

// File: rtl/dma_attr_regs.sv
module dma_attr_regs
  import dma_attr_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NUM_CH    = DATA_W,
  localparam int MAP_WORDS = NUM_CH * MAP_BITS / DATA_W,
  localparam int IDX_W     = (MAP_WORDS > 1) ? $clog2(MAP_WORDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_sel,
  input  logic                         reg_wr,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic [NUM_CH-1:0]            xfer_done,
  input  logic                         bus_err,
  input  logic [NUM_CH-1:0]            periph_req,
  output logic                         master_en,
  output logic [NUM_CH-1:0]            chan_en,
  output logic [NUM_CH-1:0]            chan_burst,
  output logic [NUM_CH-1:0]            chan_alt,
  output logic [NUM_CH-1:0]            chan_prio,
  output logic [NUM_CH-1:0]            chan_mask,
  output logic [NUM_CH-1:0]            sw_req,
  output logic [NUM_CH-1:0]            req_to_engine,
  output logic [NUM_CH-1:0]            done_status,
  output logic                         err_pending,
  output logic [NUM_CH*MAP_BITS-1:0]   chan_map,
  output logic [DATA_W-1:0]            table_base
);
  logic                     wr_go;
  logic                     hit_run, hit_base, hit_swreq, hit_err, hit_stat, hit_map;
  logic                     run_q;
  logic [DATA_W-1:BASE_LSB] base_q;
  logic [NUM_CH-1:0]        swreq_q, swreq_nxt;
  logic [NUM_CH-1:0]        stat_q, stat_nxt;
  logic                     err_q, err_nxt;
  logic [DATA_W-1:0]        alt_base;
  logic [NUM_CH-1:0]        attr_q [N_ATTR];

  assign wr_go     = reg_sel & reg_wr;
  assign hit_run   = wr_go && (reg_addr == A_RUN);
  assign hit_base  = wr_go && (reg_addr == A_BASE);
  assign hit_swreq = wr_go && (reg_addr == A_SWREQ);
  assign hit_err   = wr_go && (reg_addr == A_ERR);
  assign hit_stat  = wr_go && (reg_addr == A_STAT);
  assign hit_map   = wr_go && (reg_addr[ADDR_W-1:IDX_W] == A_MAP0[ADDR_W-1:IDX_W]);

  // Per-channel attribute vectors, each with a raise and a drop address
  for (genvar k = 0; k < N_ATTR; k++) begin : g_attr
    logic              set_hit, clr_hit;
    logic [NUM_CH-1:0] hwc;
    assign set_hit = wr_go && (reg_addr == regaddr_t'(A_ATTR0 + 2*k));
    assign clr_hit = wr_go && (reg_addr == regaddr_t'(A_ATTR0 + 2*k + 1));
    if (k == AT_EN) begin : g_done
      assign hwc = xfer_done;
    end else begin : g_nodone
      assign hwc = '0;
    end
    dma_bitvec #(.W(NUM_CH)) u_vec (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_hit),
      .clr_we (clr_hit),
      .wmask  (reg_wdata),
      .hw_clr (hwc),
      .q      (attr_q[k])
    );
  end

  dma_chmap #(.DATA_W(DATA_W), .WORDS(MAP_WORDS)) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (hit_map),
    .idx      (reg_addr[IDX_W-1:0]),
    .wdata    (reg_wdata),
    .map_flat (chan_map)
  );

  // Next-state logic
  always_comb begin
    swreq_nxt = (hit_swreq && run_q) ? reg_wdata : '0;
    stat_nxt  = stat_q;
    if (hit_stat) stat_nxt = stat_nxt & ~reg_wdata;
    stat_nxt  = stat_nxt | xfer_done;
    err_nxt   = err_q;
    if (hit_err && reg_wdata[0]) err_nxt = 1'b0;
    if (bus_err) err_nxt = 1'b1;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      base_q  <= '0;
      swreq_q <= '0;
      stat_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      if (hit_run)  run_q  <= reg_wdata[0];
      if (hit_base) base_q <= reg_wdata[DATA_W-1:BASE_LSB];
      swreq_q <= swreq_nxt;
      stat_q  <= stat_nxt;
      err_q   <= err_nxt;
    end
  end

  assign table_base    = {base_q, {BASE_LSB{1'b0}}};
  assign alt_base      = table_base | DATA_W'(ALT_OFS);
  assign master_en     = run_q;
  assign chan_en       = attr_q[AT_EN];
  assign chan_burst    = attr_q[AT_BURST];
  assign chan_alt      = attr_q[AT_ALT];
  assign chan_prio     = attr_q[AT_PRIO];
  assign chan_mask     = attr_q[AT_MASK];
  assign sw_req        = swreq_q;
  assign done_status   = stat_q;
  assign err_pending   = err_q;
  assign req_to_engine = periph_req & chan_en & ~chan_mask & {NUM_CH{run_q}};

  // Read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_RUN:     reg_rdata = DATA_W'(run_q);
      A_BASE:    reg_rdata = table_base;
      A_ALTBASE: reg_rdata = alt_base;
      A_ERR:     reg_rdata = DATA_W'(err_q);
      A_STAT:    reg_rdata = stat_q;
      default:   reg_rdata = '0;
    endcase
    for (int k = 0; k < N_ATTR; k++) begin
      if (reg_addr == regaddr_t'(A_ATTR0 + 2*k)) reg_rdata = attr_q[k];
    end
    if (reg_addr[ADDR_W-1:IDX_W] == A_MAP0[ADDR_W-1:IDX_W])
      reg_rdata = chan_map[reg_addr[IDX_W-1:0]*DATA_W +: DATA_W];
  end

  assert_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|xfer_done) |=> ((done_status & $past(xfer_done)) == $past(xfer_done)));

  assert_swreq_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hit_swreq) |-> (sw_req == '0));

  assert_swreq_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|sw_req) |-> $past(master_en));

  assert_err_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> err_pending);

  assert_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_to_engine) |-> (master_en && ((req_to_engine & chan_mask) == '0)));
endmodule

// File: tb/sim_dma_attr_regs.sv
`timescale 1ns/1ps
module sim_dma_attr_regs;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_sel = 1'b0, reg_wr = 1'b0;
  logic [4:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic [31:0]  xfer_done = '0;
  logic         bus_err = 1'b0;
  logic [31:0]  periph_req = '0;
  logic         master_en, err_pending;
  logic [31:0]  chan_en, chan_burst, chan_alt, chan_prio, chan_mask;
  logic [31:0]  sw_req, req_to_engine, done_status, table_base;
  logic [127:0] chan_map;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_attr_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .xfer_done(xfer_done), .bus_err(bus_err), .periph_req(periph_req),
    .master_en(master_en), .chan_en(chan_en), .chan_burst(chan_burst),
    .chan_alt(chan_alt), .chan_prio(chan_prio), .chan_mask(chan_mask),
    .sw_req(sw_req), .req_to_engine(req_to_engine), .done_status(done_status),
    .err_pending(err_pending), .chan_map(chan_map), .table_base(table_base)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    #1;
    d = reg_rdata;
    reg_sel = 1'b0;
  endtask

  function automatic logic [31:0] port_of(input int k);
    case (k)
      0: return chan_en;
      1: return chan_burst;
      2: return chan_alt;
      3: return chan_prio;
      default: return chan_mask;
    endcase
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    for (int k = 0; k < 5; k++) begin
      rd(5'(4 + 2*k), d);
      chk("R3 reset vector read", d, 32'h0);
    end
    chk("R5 reset run bit", {31'b0, master_en}, 32'h0);
    chk("R7 reset error", {31'b0, err_pending}, 32'h0);
    chk("R8 reset status", done_status, 32'h0);
  endtask

  task automatic t_vectors;
    logic [31:0] d;
    for (int k = 0; k < 5; k++) begin
      wr(5'(4 + 2*k), 32'hA5A5_0F0F);
      rd(5'(4 + 2*k), d);
      chk("R1 raise pattern read", d, 32'hA5A5_0F0F);
      chk("R1 raise pattern port", port_of(k), 32'hA5A5_0F0F);
      wr(5'(4 + 2*k), 32'h0000_0010);
      rd(5'(4 + 2*k), d);
      chk("R1 raise adds bit", d, 32'hA5A5_0F1F);
      wr(5'(5 + 2*k), 32'h0000_0F00);
      rd(5'(4 + 2*k), d);
      chk("R2 drop partial", d, 32'hA5A5_001F);
      wr(5'(4 + 2*k), 32'h0);
      wr(5'(5 + 2*k), 32'h0);
      rd(5'(4 + 2*k), d);
      chk("R2 zero writes no effect", d, 32'hA5A5_001F);
      rd(5'(5 + 2*k), d);
      chk("R3 drop address reads zero", d, 32'h0);
      wr(5'(5 + 2*k), 32'hFFFF_FFFF);
      chk("R2 drop all port", port_of(k), 32'h0);
    end
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(5'h00, 32'h1);
    rd(5'h00, d);
    chk("R5 run bit read", d, 32'h1);
    wr(5'h04, 32'h0000_00FF);
    wr(5'h0C, 32'h0000_000F);
    @(negedge clk);
    periph_req = 32'hFFFF_FFFF;
    #1;
    chk("R11 enabled unmasked requests", req_to_engine, 32'h0000_00F0);
    wr(5'h00, 32'h0);
    #1;
    chk("R5 requests blocked when off", req_to_engine, 32'h0);
    @(negedge clk);
    periph_req = '0;
    wr(5'h05, 32'hFFFF_FFFF);
    wr(5'h0D, 32'hFFFF_FFFF);
  endtask

  task automatic t_swreq;
    logic [31:0] d;
    wr(5'h00, 32'h1);
    wr(5'h03, 32'h8000_0001);
    chk("R6 pulse in cycle after write", sw_req, 32'h8000_0001);
    @(posedge clk); #1;
    chk("R6 pulse ends", sw_req, 32'h0);
    rd(5'h03, d);
    chk("R3 request address reads zero", d, 32'h0);
    wr(5'h00, 32'h0);
    wr(5'h03, 32'h0000_00FF);
    chk("R5 no pulse when off", sw_req, 32'h0);
  endtask

  task automatic t_done;
    logic [31:0] d;
    wr(5'h04, 32'h0000_0028);
    @(negedge clk);
    xfer_done = 32'h0000_0008;
    @(posedge clk); #1;
    xfer_done = '0;
    chk("R4 completion drops own enable", chan_en, 32'h0000_0020);
    chk("R4 completion sets status", done_status, 32'h0000_0008);
    wr(5'h0F, 32'hFFFF_FFFF);
    wr(5'h05, 32'hFFFF_FFFF);
  endtask

  task automatic t_status;
    logic [31:0] d;
    @(negedge clk);
    xfer_done = 32'h0000_0086;
    @(posedge clk); #1;
    xfer_done = '0;
    rd(5'h0F, d);
    chk("R8 several status bits", d, 32'h0000_0086);
    wr(5'h0F, 32'h0000_0002);
    rd(5'h0F, d);
    chk("R8 clear one bit", d, 32'h0000_0084);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = 5'h0F; reg_wdata = 32'h0000_0004;
    xfer_done = 32'h0000_0004;
    @(posedge clk); #1;
    reg_sel = 1'b0; reg_wr = 1'b0; xfer_done = '0;
    chk("R8 completion wins over clear", done_status, 32'h0000_0084);
  endtask

  task automatic t_err;
    logic [31:0] d;
    @(negedge clk);
    bus_err = 1'b1;
    @(posedge clk); #1;
    bus_err = 1'b0;
    rd(5'h0E, d);
    chk("R7 error reads set", d, 32'h1);
    wr(5'h0E, 32'h0);
    rd(5'h0E, d);
    chk("R7 zero write keeps error", d, 32'h1);
    wr(5'h0E, 32'h1);
    rd(5'h0E, d);
    chk("R7 one write clears error", d, 32'h0);
  endtask

  task automatic t_map;
    logic [31:0] d;
    wr(5'h11, 32'h7654_3210);
    rd(5'h11, d);
    chk("R9 map word read", d, 32'h7654_3210);
    chk("R9 channel 8 nibble", {28'b0, chan_map[35:32]}, 32'h0);
    chk("R9 channel 15 nibble", {28'b0, chan_map[63:60]}, 32'h7);
    chk("R9 channel 10 nibble", {28'b0, chan_map[43:40]}, 32'h2);
    rd(5'h10, d);
    chk("R9 other word untouched", d, 32'h0);
  endtask

  task automatic t_base;
    logic [31:0] d;
    wr(5'h01, 32'h2000_07FF);
    rd(5'h01, d);
    chk("R10 base low bits ignored", d, 32'h2000_0400);
    rd(5'h02, d);
    chk("R10 alternate base", d, 32'h2000_0600);
    chk("R10 base port", table_base, 32'h2000_0400);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_vectors();
    t_gate();
    t_swreq();
    t_done();
    t_status();
    t_err();
    t_map();
    t_base();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule